// File: doc/BRIEF.md
# Shared Retry Line Driver with Release-then-Precharge Negation

This block drives one agent's share of an active-low address-retry line. Several snooping agents may pull that line low at the same moment. When local snoop logic asks for a retry, the block pulls the line low a fixed number of bus cycles after the start-of-tenure strobe. It holds the line low until the bus cycle after the address acknowledge. It then lets go in two steps. First the pad floats for half a bus cycle. Then it drives the line high for one bus cycle, which recharges the wire, and after that it floats again. A configuration input turns off the recharge step, so the pad simply floats once the low interval ends.

The block runs on a clock at twice the bus frequency. The input `bus_tick` is high on the fast-clock edges that fall on bus clock edges. The strobe, request and acknowledge inputs are sampled only on those edges. This lets the float interval last exactly one fast-clock period. The outputs are an enable and a value for a tri-state pad. Only a low value is ever driven for longer than one bus cycle.

Top module: `retry_line_drv`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the edge after it, `line_oe_o` is 0 and `line_val_o` is 1.
- R2: `tenure_start_i`, `addr_ack_i` and `retry_req_i` are sampled only on edges where `bus_tick` is 1. Pulses on other edges have no effect on the outputs.
- R3: Take the tick edge that samples the start strobe as T0. If `retry_req_i` is sampled high on any tick from T0+1 to T0+LEAD_CYC, the line is driven low (`line_oe_o`=1, `line_val_o`=0) from tick edge T0+LEAD_CYC. A request sampled on T0 itself, or after T0+LEAD_CYC, does not count.
- R4: If no request is sampled in that window, `line_oe_o` stays 0 for the whole tenure.
- R5: Let A be the tick edge that samples `addr_ack_i`, taken from ticks T0+1 onward. The low drive ends at tick edge max(A, T0+LEAD_CYC)+1.
- R6: When the low drive ends, `line_oe_o` is 0 for the next fast-clock period, which is half a bus cycle.
- R7: With `pchg_dis_i` low, the line is then driven high (`line_oe_o`=1, `line_val_o`=1) for exactly two fast-clock periods, which is one bus cycle, and afterwards `line_oe_o` returns to 0.
- R8: `pchg_dis_i` is sampled on the tick edge where the low drive ends. If it is 1 there, the high drive is skipped and `line_oe_o` stays 0.
- R9: A start strobe sampled while a tenure or its negation is still in progress is held, one deep. The new tenure then takes as its T0 the first tick edge at which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_tick | input | 1 | High on fast edges that coincide with bus clock edges |
| tenure_start_i | input | 1 | Start-of-address-tenure strobe |
| addr_ack_i | input | 1 | Address acknowledge strobe |
| retry_req_i | input | 1 | Retry request from local snoop logic |
| pchg_dis_i | input | 1 | When high, skip the driven-high recharge cycle |
| line_oe_o | output | 1 | Pad output enable |
| line_val_o | output | 1 | Pad output value (0 = retry asserted) |

## Verification
The bench builds the block with LEAD_CYC at its default of 2. With that value the request window covers only two ticks, so a request just before the window, inside it, or just after it can be placed by hand. It also makes it easy to place an acknowledge that arrives before the assertion point, on it, or after it. The short tenures leave time to drop a second strobe into every phase of a running sequence, including the wait, low, float and recharge phases and the disabled-recharge case, and then to check where the queued tenure begins.

// File: rtl/retry_line_drv.sv
`timescale 1ns/1ps
module retry_line_drv #(
  parameter int LEAD_CYC = 2,
  localparam int CW = (LEAD_CYC > 2) ? $clog2(LEAD_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_tick,
  input  logic tenure_start_i,
  input  logic addr_ack_i,
  input  logic retry_req_i,
  input  logic pchg_dis_i,
  output logic line_oe_o,
  output logic line_val_o
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_LOW, S_FLOAT, S_HIGH} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic          req_seen, ack_seen, start_q, half;

  wire start_now = bus_tick & (tenure_start_i | start_q);
  wire go        = req_seen | retry_req_i;
  wire decide    = (cnt == CW'(LEAD_CYC - 1));

  assign line_oe_o  = (st == S_LOW) || (st == S_HIGH);
  assign line_val_o = (st != S_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      req_seen <= 1'b0;
      ack_seen <= 1'b0;
      start_q  <= 1'b0;
      half     <= 1'b0;
    end else begin
      if (bus_tick && tenure_start_i && st != S_IDLE)
        start_q <= 1'b1;
      case (st)
        S_IDLE: if (start_now) begin
          st       <= S_WAIT;
          cnt      <= '0;
          req_seen <= 1'b0;
          ack_seen <= 1'b0;
          start_q  <= 1'b0;
        end
        S_WAIT: if (bus_tick) begin
          if (decide) begin
            st       <= go ? S_LOW : S_IDLE;
            ack_seen <= ack_seen | addr_ack_i;
          end else begin
            cnt      <= cnt + 1'b1;
            req_seen <= go;
            ack_seen <= ack_seen | addr_ack_i;
          end
        end
        S_LOW: if (bus_tick) begin
          if (ack_seen) st <= pchg_dis_i ? S_IDLE : S_FLOAT;
          else if (addr_ack_i) ack_seen <= 1'b1;
        end
        S_FLOAT: begin
          st   <= S_HIGH;
          half <= 1'b0;
        end
        S_HIGH: begin
          if (half) st <= S_IDLE;
          half <= ~half;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire drv_low  = line_oe_o & ~line_val_o;
  wire drv_high = line_oe_o & line_val_o;

  p_low_starts_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_low) |-> $past(bus_tick));

  p_low_ends_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_low) |-> $past(bus_tick));

  p_float_after_low_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_low) |-> !line_oe_o);

  p_high_follows_float_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv_low) && !$past(pchg_dis_i)) |=> drv_high);

  p_high_two_cycles_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_high) |=> drv_high);

  p_high_then_release_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(drv_high) && drv_high) |=> !line_oe_o);

  p_no_high_when_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv_low) && $past(pchg_dis_i)) |=> !line_oe_o);

  p_high_only_after_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_high) |-> $past(!line_oe_o, 1) && $past(drv_low, 2));

endmodule

// File: tb/retry_line_drv_test.sv
`timescale 1ns/1ps
module retry_line_drv_test;
  localparam int LEAD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_tick = 1'b0, ts = 1'b0, ack = 1'b0, req = 1'b0, dis = 1'b0;
  logic oe, val;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  retry_line_drv #(.LEAD_CYC(LEAD)) uut (
    .clk(clk), .rst(rst), .bus_tick(bus_tick), .tenure_start_i(ts),
    .addr_ack_i(ack), .retry_req_i(req), .pchg_dis_i(dis),
    .line_oe_o(oe), .line_val_o(val));

  function automatic logic [1:0] expect_line(int k, int req_e, int d, bit pd);
    int n;
    bit go;
    go = (req_e >= 2) && (req_e <= 2*LEAD) && (req_e % 2 == 0);
    if (!go || k < 2*LEAD) return 2'b01;
    n = ((d > LEAD) ? d : LEAD) + 1;
    if (k < 2*n) return 2'b10;
    if (pd || k == 2*n) return 2'b01;
    if (k <= 2*n + 2) return 2'b11;
    return 2'b01;
  endfunction

  function automatic string tag_of(int k, int req_e, int d, bit pd);
    int n;
    bit go;
    go = (req_e >= 2) && (req_e <= 2*LEAD) && (req_e % 2 == 0);
    if (!go) return "R4";
    n = ((d > LEAD) ? d : LEAD) + 1;
    if (k <= 2*LEAD) return "R3";
    if (k < 2*n) return "R5";
    if (pd) return "R8";
    if (k == 2*n) return "R6";
    return "R7";
  endfunction

  function automatic int idle_tick(int req_e, int d, bit pd);
    int n;
    bit go;
    go = (req_e >= 2) && (req_e <= 2*LEAD) && (req_e % 2 == 0);
    if (!go) return 2*LEAD + 2;
    n = ((d > LEAD) ? d : LEAD) + 1;
    return pd ? 2*n + 2 : 2*n + 4;
  endfunction

  task automatic check(string tag, logic [1:0] exp);
    n_run++;
    if ({oe, val} !== exp) begin
      n_fail++;
      $display("FAIL %s: oe/val actual %b%b expected %b%b at %0t", tag, oe, val, exp[1], exp[0], $time);
    end
  endtask

  task automatic step(bit tk, bit s, bit a, bit r);
    bus_tick = tk; ts = s; ack = a; req = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_bus(int cycles);
    for (int i = 0; i < cycles; i++) begin
      step(1, 0, 0, 0); check("R4", 2'b01);
      step(0, 0, 0, 0); check("R4", 2'b01);
    end
  endtask

  task automatic run_tenure(int req_e, int d, bit pd, int ts2_e);
    int t2, e_end;
    logic [1:0] ex;
    string tg;
    bit s, a, r;
    dis = pd;
    t2 = idle_tick(req_e, d, pd);
    e_end = (ts2_e >= 0) ? t2 + 10 : t2;
    for (int e = 0; e < e_end; e++) begin
      if (e % 2 == 1) begin
        s = 1'($urandom % 2); a = 1'($urandom % 2); r = 1'($urandom % 2);
        step(0, s, a, r);
      end else if (ts2_e >= 0 && e >= t2) begin
        step(1, (e == ts2_e), (e == t2 + 4), (e == t2 + 2));
      end else begin
        step(1, (e == 0) || (e == ts2_e), (e == 2*d), (e == req_e));
      end
      if (ts2_e >= 0 && e >= t2) begin
        ex = expect_line(e - t2, 2, 2, pd);
        tg = "R9";
      end else begin
        ex = expect_line(e, req_e, d, pd);
        tg = tag_of(e, req_e, d, pd);
      end
      check(tg, ex);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int req_e, d, ts2_e, t2;
    bit pd;
    void'($urandom(32'd1234));
    @(negedge clk);
    step(1, 1, 0, 1); check("R1", 2'b01);
    step(0, 0, 0, 0); check("R1", 2'b01);
    rst = 1'b0;
    idle_bus(2);

    // R2: strobes only on non-tick edges
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, 0); check("R2", 2'b01);
      step(0, 1, 1, 1); check("R2", 2'b01);
    end

    // R3/R4: request sampled with the strobe only, or too late
    run_tenure(0, 2, 0, -1);
    run_tenure(6, 2, 0, -1);
    // R3/R5/R6/R7: request at each window tick, acknowledge before, on and after start
    run_tenure(2, 1, 0, -1);
    run_tenure(4, 2, 0, -1);
    run_tenure(2, 4, 0, -1);
    // R8: recharge disabled
    run_tenure(4, 3, 1, -1);
    // R9: second strobe during low, float/recharge, and at the disabled release tick
    run_tenure(2, 2, 0, 4);
    run_tenure(2, 2, 0, 8);
    run_tenure(2, 2, 1, 6);
    run_tenure(0, 2, 0, 2);

    // R1: reset in the middle of a low drive
    step(1, 1, 0, 0); step(0, 0, 0, 0);
    step(1, 0, 0, 1); step(0, 0, 0, 0);
    step(1, 0, 0, 0); check("R3", 2'b10);
    rst = 1'b1;
    step(0, 0, 0, 0); check("R1", 2'b01);
    step(1, 0, 0, 0); check("R1", 2'b01);
    rst = 1'b0;
    step(0, 0, 0, 0); check("R1", 2'b01);
    idle_bus(1);

    for (int i = 0; i < 60; i++) begin
      case ($urandom % 5)
        0: req_e = 0;
        1: req_e = 2;
        2: req_e = 4;
        3: req_e = 6;
        default: req_e = -1;
      endcase
      d  = 1 + int'($urandom % 4);
      pd = 1'($urandom % 2);
      t2 = idle_tick(req_e, d, pd);
      ts2_e = ($urandom % 2 == 0) ? -1 : 2 * (1 + int'($urandom % (t2 / 2)));
      run_tenure(req_e, d, pd, ts2_e);
      idle_bus(int'($urandom % 3));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule